// File: doc/BRIEF.md
# I2S Stereo Receiver with Frame-Rate Meter

This block takes a stereo I2S stream, given as a bit clock, a word-select (left/right) clock and a serial data line, and turns it into parallel left/right sample pairs. All three serial inputs are brought into the system clock domain and sampled there, so the block runs entirely on the system clock. Each channel word is reduced to a fixed 20-bit sample, whatever length the sender uses. A word longer than 20 bits keeps its leading bits. A shorter word is padded with zeros at the low end. Completed pairs go out on a valid/ready handshake.

Alongside the data path, a rate meter counts word-select frames over a fixed window of system-clock cycles. The window is set to one sixtieth of a second. The count is published as a read-only field. Multiplying the field by 60 gives the incoming sample rate in samples per second, so a 48 kHz stream reads 800 and an 8 kHz stream reads 133. With the default parameters the meter covers input rates from 8 to 48 kilosamples per second and well beyond.

Top module: `i2s_rx_meter`

## Requirements
- R1: After reset, `pair_valid` is 0, `overrun` is 0 and `rate_count` is 0.
- R2: Data is sampled on rising bit-clock edges, MSB first. The left word is sent while the word-select clock is low (0) and the right word while it is high (1). A word's MSB arrives one bit-clock period after the word-select transition that starts it, and its LSB arrives on the first bit-clock period after the following transition. A 20-bit word appears unchanged on `left_sample`/`right_sample`, with its MSB at bit 19.
- R3: For a channel word of more than 20 bits, the first 20 received bits (the most significant) form the sample and the remaining bits are discarded.
- R4: For a channel word of fewer than N=20 bits, the received bits occupy sample bits 19 downward and every lower bit is 0.
- R5: A pair is output only when a left word and the right word that follows it in the same frame were both started by an observed word-select transition. The partial frame seen first after reset is therefore never output.
- R6: While `pair_valid` is 1 and `pair_ready` is 0, `pair_valid`, `left_sample` and `right_sample` keep their values.
- R7: If a frame completes while a pair is still waiting (`pair_valid`=1, `pair_ready`=0), the new frame is discarded and `overrun` becomes 1. `overrun` stays 1 until reset.
- R8: At the end of every window of `WINDOW_CYCLES` system clocks, `rate_count` takes the number of word-select rising edges seen in that window. It keeps that value until the next window ends.
- R9: The frame count saturates at 2^RATE_W-1.
- R10: A window with no word-select rising edge sets `rate_count` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| lrclk_in | input | 1 | Word-select clock: 0 = left, 1 = right |
| sdata_in | input | 1 | Serial data, MSB first |
| pair_valid | output | 1 | A left/right pair is available |
| pair_ready | input | 1 | The consumer accepts the pair this cycle |
| left_sample | output | SAMPLE_W | Left channel, normalised to SAMPLE_W bits |
| right_sample | output | SAMPLE_W | Right channel, normalised to SAMPLE_W bits |
| overrun | output | 1 | Sticky flag: a frame was discarded |
| rate_count | output | RATE_W | Frames counted in the last window |

## Verification
The bench builds the block with a window of 1920 system clocks and a 6-bit rate field. These values let a full window pass in a few thousand cycles, and they make the saturation limit of 63 reachable with a fast four-bit-word stream. The bit clock runs at one or two system clocks per half period. Word lengths of 4, 16, 20, 24 and 32 bits exercise the exact, truncating and zero-filling paths. Frame periods of 128 and 96 cycles give known ideal counts of 15 and 20 per window.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  // Lane positions inside the synchronised input bundle.
  localparam int LANE_BCLK = 0;
  localparam int LANE_WS   = 1;
  localparam int LANE_SD   = 2;
  localparam int IN_LANES  = 3;

  // Channel selected by the word-select level.
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } i2s_chan_e;
endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= async_in;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
  import i2s_rx_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk_lvl,
  input  logic                ws_lvl,
  input  logic                sd_lvl,
  input  logic                pair_ready_i,
  output logic                pair_valid_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                overrun_o
);
  localparam int CW = $clog2(SAMPLE_W + 1);

  logic                bclk_q;
  logic                bit_stb;
  i2s_chan_e           chan_q;
  logic                started_q;
  logic                left_ok_q;
  logic [SAMPLE_W-1:0] shreg_q;
  logic [SAMPLE_W-1:0] left_hold_q;
  logic [CW-1:0]       bit_cnt_q;
  logic [CW-1:0]       bit_idx;
  logic [SAMPLE_W-1:0] ins_word;
  logic                ws_change;
  logic                frame_done;

  assign bit_stb   = bclk_lvl & ~bclk_q;
  assign ws_change = bit_stb && (i2s_chan_e'(ws_lvl) != chan_q);
  assign bit_idx   = CW'(SAMPLE_W - 1) - bit_cnt_q;

  // Place the incoming bit at the next free MSB-side slot; bits past the
  // sample width fall away, unfilled slots stay zero.
  always_comb begin
    ins_word = shreg_q;
    if (bit_cnt_q < CW'(SAMPLE_W)) ins_word[bit_idx] = sd_lvl;
  end

  assign frame_done = ws_change && (chan_q == CH_RIGHT) && started_q && left_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q      <= 1'b0;
      chan_q      <= CH_LEFT;
      started_q   <= 1'b0;
      left_ok_q   <= 1'b0;
      shreg_q     <= '0;
      left_hold_q <= '0;
      bit_cnt_q   <= '0;
    end else begin
      bclk_q <= bclk_lvl;
      if (ws_change) begin
        if (chan_q == CH_LEFT) begin
          left_hold_q <= ins_word;
          left_ok_q   <= started_q;
        end else begin
          left_ok_q   <= 1'b0;
        end
        started_q <= 1'b1;
        chan_q    <= i2s_chan_e'(ws_lvl);
        shreg_q   <= '0;
        bit_cnt_q <= '0;
      end else if (bit_stb) begin
        shreg_q <= ins_word;
        if (bit_cnt_q < CW'(SAMPLE_W)) bit_cnt_q <= bit_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_valid_o <= 1'b0;
      left_o       <= '0;
      right_o      <= '0;
      overrun_o    <= 1'b0;
    end else begin
      if (frame_done) begin
        if (!pair_valid_o || pair_ready_i) begin
          pair_valid_o <= 1'b1;
          left_o       <= left_hold_q;
          right_o      <= ins_word;
        end else begin
          overrun_o <= 1'b1;
        end
      end else if (pair_valid_o && pair_ready_i) begin
        pair_valid_o <= 1'b0;
      end
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pair_valid_o && !pair_ready_i) |=>
      (pair_valid_o && $stable(left_o) && $stable(right_o)));

  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_done && pair_valid_o && !pair_ready_i) |=> overrun_o);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);
endmodule

// File: rtl/i2s_rx_ratemeter.sv
module i2s_rx_ratemeter #(
  parameter int WINDOW_CYCLES = 1666667,
  parameter int RATE_W        = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ws_lvl,
  output logic [RATE_W-1:0] rate_o
);
  localparam int WIN_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [RATE_W-1:0] CNT_MAX = '1;

  logic              ws_q;
  logic              frame_stb;
  logic [WIN_W-1:0]  win_cnt_q;
  logic              win_end;
  logic [RATE_W-1:0] frame_cnt_q;
  logic [RATE_W-1:0] frame_next;

  assign frame_stb  = ws_lvl & ~ws_q;
  assign win_end    = (win_cnt_q == WIN_W'(WINDOW_CYCLES - 1));
  assign frame_next = (frame_stb && frame_cnt_q != CNT_MAX) ? frame_cnt_q + 1'b1 : frame_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q        <= 1'b0;
      win_cnt_q   <= '0;
      frame_cnt_q <= '0;
      rate_o      <= '0;
    end else begin
      ws_q <= ws_lvl;
      if (win_end) begin
        win_cnt_q   <= '0;
        rate_o      <= frame_next;
        frame_cnt_q <= '0;
      end else begin
        win_cnt_q   <= win_cnt_q + 1'b1;
        frame_cnt_q <= frame_next;
      end
    end
  end

  assert_rate_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(rate_o));

  assert_rate_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (win_end && frame_cnt_q == '0 && !frame_stb) |=> (rate_o == '0));
endmodule

// File: rtl/i2s_rx_meter.sv
module i2s_rx_meter
  import i2s_rx_pkg::*;
#(
  parameter int SAMPLE_W      = 20,
  parameter int RATE_W        = 13,
  parameter int WINDOW_CYCLES = 1666667,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk_in,
  input  logic                lrclk_in,
  input  logic                sdata_in,
  output logic                pair_valid,
  input  logic                pair_ready,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                overrun,
  output logic [RATE_W-1:0]   rate_count
);
  logic [IN_LANES-1:0] raw_in;
  logic [IN_LANES-1:0] lane_sync;

  always_comb begin
    raw_in            = '0;
    raw_in[LANE_BCLK] = bclk_in;
    raw_in[LANE_WS]   = lrclk_in;
    raw_in[LANE_SD]   = sdata_in;
  end

  i2s_rx_sync #(.WIDTH(IN_LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (raw_in),
    .sync_out (lane_sync)
  );

  i2s_rx_deser #(.SAMPLE_W(SAMPLE_W)) u_deser (
    .clk          (clk),
    .rst          (rst),
    .bclk_lvl     (lane_sync[LANE_BCLK]),
    .ws_lvl       (lane_sync[LANE_WS]),
    .sd_lvl       (lane_sync[LANE_SD]),
    .pair_ready_i (pair_ready),
    .pair_valid_o (pair_valid),
    .left_o       (left_sample),
    .right_o      (right_sample),
    .overrun_o    (overrun)
  );

  i2s_rx_ratemeter #(.WINDOW_CYCLES(WINDOW_CYCLES), .RATE_W(RATE_W)) u_rate (
    .clk    (clk),
    .rst    (rst),
    .ws_lvl (lane_sync[LANE_WS]),
    .rate_o (rate_count)
  );
endmodule

// File: tb/i2s_rx_meter_tb.sv
module i2s_rx_meter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW  = 20;
  localparam int RW  = 6;
  localparam int WIN = 1920;
  localparam int MAXQ = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0, ready = 1'b0;
  logic pair_valid, overrun;
  logic [SW-1:0] left_s, right_s;
  logic [RW-1:0] rate;

  int checks = 0;
  int errors = 0;
  logic [SW-1:0] exp_l [MAXQ];
  logic [SW-1:0] exp_r [MAXQ];
  int            exp_wl [MAXQ];
  bit            exp_drop [MAXQ];
  int exp_n = 0;
  int rx_ptr = 0;
  logic last_bit = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_rx_meter #(.SAMPLE_W(SW), .RATE_W(RW), .WINDOW_CYCLES(WIN), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .bclk_in(bclk), .lrclk_in(lrclk), .sdata_in(sdata),
    .pair_valid(pair_valid), .pair_ready(ready),
    .left_sample(left_s), .right_sample(right_s),
    .overrun(overrun), .rate_count(rate));

  function automatic logic [SW-1:0] norm(logic [31:0] w, int wl);
    logic [SW-1:0] r;
    r = '0;
    for (int b = 0; b < SW; b++) begin
      if (wl - 1 - b >= 0) r[SW-1-b] = w[wl-1-b];
    end
    return r;
  endfunction

  function automatic int ideal_rate(int wl, int h);
    int n;
    n = WIN / (4 * wl * h);
    if (n > (1 << RW) - 1) n = (1 << RW) - 1;
    return n;
  endfunction

  function automatic string len_tag(int wl);
    if (wl > SW) return "R3";
    if (wl < SW) return "R4";
    return "R2";
  endfunction

  task automatic check(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic slot(logic ws, logic d, int h);
    @(negedge clk);
    bclk = 1'b0; lrclk = ws; sdata = d;
    repeat (h) @(negedge clk);
    bclk = 1'b1;
    repeat (h - 1) @(negedge clk);
  endtask

  task automatic send_frame(int wl, int h, bit drop);
    logic [31:0] lw, rw, mask;
    lw = $urandom; rw = $urandom;
    mask = (wl >= 32) ? 32'hFFFF_FFFF : 32'((64'd1 << wl) - 1);
    lw &= mask; rw &= mask;
    exp_l[exp_n] = norm(lw, wl);
    exp_r[exp_n] = norm(rw, wl);
    exp_wl[exp_n] = wl;
    exp_drop[exp_n] = drop;
    exp_n++;
    for (int j = 0; j < wl; j++) slot(1'b0, (j == 0) ? last_bit : lw[wl-j], h);
    for (int j = 0; j < wl; j++) slot(1'b1, (j == 0) ? lw[0] : rw[wl-j], h);
    last_bit = rw[0];
  endtask

  task automatic set_ready(logic v);
    @(posedge clk);
    #2 ready = v;
  endtask

  // Pair monitor: compares each accepted pair with the next kept frame.
  always @(negedge clk) begin
    if (!rst && pair_valid && ready) begin
      while (rx_ptr < exp_n && exp_drop[rx_ptr]) rx_ptr++;
      if (rx_ptr >= exp_n) begin
        check(1'b0, "R5 unexpected pair", 1, 0);
      end else begin
        check(left_s == exp_l[rx_ptr], {len_tag(exp_wl[rx_ptr]), " left sample"},
              longint'(left_s), longint'(exp_l[rx_ptr]));
        check(right_s == exp_r[rx_ptr], {len_tag(exp_wl[rx_ptr]), " right sample"},
              longint'(right_s), longint'(exp_r[rx_ptr]));
        rx_ptr++;
      end
    end
  end

  task automatic rate_run(int wl, int h, int nframes, string tag);
    int exp_rate;
    exp_rate = ideal_rate(wl, h);
    fork
      begin
        for (int f = 0; f < nframes; f++) send_frame(wl, h, 1'b0);
      end
      begin
        repeat (4200) @(negedge clk);
        if (exp_rate == (1 << RW) - 1)
          check(rate == RW'(exp_rate), tag, rate, exp_rate);
        else
          check((int'(rate) >= exp_rate - 1) && (int'(rate) <= exp_rate + 1), tag, rate, exp_rate);
      end
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(pair_valid == 1'b0, "R1 pair_valid", pair_valid, 0);
    check(overrun == 1'b0, "R1 overrun", overrun, 0);
    check(rate == '0, "R1 rate_count", rate, 0);

    set_ready(1'b1);
    // R5: partial first frame is never delivered
    send_frame(20, 2, 1'b1);
    // R2: exact 20-bit words
    for (int i = 0; i < 8; i++) send_frame(20, 2, 1'b0);
    // R3: longer words truncated
    for (int i = 0; i < 3; i++) send_frame(24, 2, 1'b0);
    for (int i = 0; i < 3; i++) send_frame(32, 1, 1'b0);
    // R4: shorter words zero-filled
    for (int i = 0; i < 3; i++) send_frame(16, 2, 1'b0);
    for (int i = 0; i < 3; i++) send_frame(4, 1, 1'b0);
    for (int i = 0; i < 4; i++) send_frame(2 + ($urandom % 30), 1 + ($urandom % 2), 1'b0);
    repeat (20) @(negedge clk);

    // R6 / R7: consumer stalls, later frames are lost
    check(overrun == 1'b0, "R7 overrun before stall", overrun, 0);
    set_ready(1'b0);
    base = exp_n;
    send_frame(20, 2, 1'b1);
    send_frame(20, 2, 1'b1);
    send_frame(20, 2, 1'b0);
    repeat (20) @(negedge clk);
    check(pair_valid == 1'b1, "R6 pair_valid held", pair_valid, 1);
    check(left_s == exp_l[base-1], "R6 left held", left_s, exp_l[base-1]);
    check(right_s == exp_r[base-1], "R6 right held", right_s, exp_r[base-1]);
    check(overrun == 1'b1, "R7 overrun set", overrun, 1);
    repeat (60) @(negedge clk);
    check(left_s == exp_l[base-1], "R6 left still held", left_s, exp_l[base-1]);
    set_ready(1'b1);

    // R8 frame-rate measurement
    rate_run(16, 2, 40, "R8 rate 128-cycle frames");
    rate_run(24, 1, 50, "R8 rate 96-cycle frames");
    // R9 saturation
    rate_run(4, 1, 300, "R9 rate saturation");

    // R10 no word-select edges
    repeat (4500) @(negedge clk);
    check(rate == '0, "R10 rate zero when idle", rate, 0);

    send_frame(20, 2, 1'b0);
    repeat (30) @(negedge clk);
    check(rx_ptr == exp_n - 1, "R5 delivered pair count", rx_ptr, exp_n - 1);
    check(overrun == 1'b1, "R7 overrun sticky", overrun, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule